// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Model

This block is a synthesizable, cycle-level model of a single DRAM bank. It holds a small array of cells, a row decoder, one row buffer and a per-row charge-retention timer. A caller issues activate, column read, column write, precharge and refresh commands on a one-cycle command strobe. Each accepted command keeps `busy` high for a latency that is fixed in clock cycles. Opening a row is slow. Closing a row is slower still. A column access is the fastest command.

Sensing is destructive. Activating a row moves its contents into the row buffer and leaves the cells cleared. Column reads and writes reach only the buffer, and only a precharge writes the buffer back into the cells. Charge also leaks. A row that is not precharged or refreshed within `RETENTION` cycles has lost its data. If that row is then opened, its reads come back as zeros and `decay_error` is raised. The model flags a command that arrives in an illegal order and otherwise ignores it.

Top module: `dbank_model`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `cmd_error` and `decay_error` are low and no row is open.
- R2: Command codes on `cmd_op` are 1 activate, 2 column read, 3 column write, 4 precharge and 5 refresh. Codes 0, 6 and 7 do nothing and raise no error. The row is taken from the upper ROW_AW bits of `cmd_addr` and the column from the lower COL_AW bits. Column c selects buffer bits [c*COL_W +: COL_W].
- R3: An accepted command holds `busy` high for exactly T_ACT cycles (activate), T_PRE cycles (precharge), T_COL cycles (read or write) or T_ACT+T_PRE cycles (refresh). A new command is accepted in the first cycle in which `busy` is low.
- R4: A column read raises `rd_valid` for one cycle, in the first cycle in which `busy` is low again. `rd_data` carries the addressed word of the row buffer.
- R5: A column write replaces the addressed word of the buffer. Activate moves the row into the buffer and clears its cells. Precharge writes the buffer back, so written data survives closing and reopening the row.
- R6: Data written to one row never changes the data of any other row.
- R7: A column read or write with no row open is ignored. It does not raise `busy` or `rd_valid`, and `cmd_error` pulses in the following cycle.
- R8: An activate or refresh issued while a row is open is ignored. It raises `cmd_error` in the following cycle, and the open row and its buffer stay as they were.
- R9: A command presented while `busy` is high is ignored and raises `cmd_error` in the following cycle.
- R10: Each row counts the cycles since its last precharge, its last refresh, or reset. If an activate is accepted at clock edge m and the count was last restarted at edge k, the row has decayed when m-1-k >= RETENTION. Reads from the buffer of a decayed row return zero with `decay_error` high alongside `rd_valid`. The next precharge writes the buffer back and restarts the count.
- R11: A refresh restarts the row's count and keeps its data when the row has not decayed. When the row has decayed, the refresh leaves it holding zeros.
- R12: A precharge with no row open changes no state, holds `busy` for T_PRE cycles and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ROW_AW+COL_AW | Row (upper bits) and column (lower bits) |
| cmd_wdata | input | COL_W | Data for a column write |
| busy | output | 1 | A command is in progress |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read data |
| rd_data | output | COL_W | Word returned by a column read |
| cmd_error | output | 1 | Pulse: the previous command was illegal and was dropped |
| decay_error | output | 1 | Pulse with `rd_valid`: the open row had decayed |

## Verification
The bench builds the block with its default geometry of 16 rows of 32 bits in 8-bit words, and with the default latencies of 4, 8 and 1 cycles. Refresh therefore takes 12 cycles. RETENTION is lowered to 600 so that decay can be reached in a few hundred idle cycles. With that value, one idle wait can push one row past the window while a second row, refreshed partway through the same wait, stays valid. The random phase refreshes every row between batches, so every row ages well inside the window and the bench model can still apply the exact decay formula.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACT = 3'd1,
      OP_RD  = 3'd2,
      OP_WR  = 3'd3,
      OP_PRE = 3'd4,
      OP_REF = 3'd5
   } dbank_op_e;

endpackage

// File: rtl/dbank_timer.sv
module dbank_timer
   import dbank_pkg::*;
#(
   parameter int T_ACT = 4,
   parameter int T_PRE = 8,
   parameter int T_COL = 1,
   localparam int T_REF = T_ACT + T_PRE,
   localparam int CW = $clog2(T_REF + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  dbank_op_e op,
   output logic      busy,
   output logic      done
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load;

   if (T_COL < 1 || T_ACT < 1 || T_PRE < 1) begin : g_bad_lat
      $error("dbank_timer: every latency must be at least one cycle");
   end

   always_comb begin
      case (op)
         OP_ACT:  load = CW'(T_ACT);
         OP_PRE:  load = CW'(T_PRE);
         OP_REF:  load = CW'(T_REF);
         default: load = CW'(T_COL);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= load;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign done = (cnt_q == CW'(1));

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R3
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !busy);

endmodule

// File: rtl/dbank_retention.sv
module dbank_retention #(
   parameter int ROWS = 16,
   parameter int RETENTION = 4096,
   localparam int ROW_AW = $clog2(ROWS),
   localparam int RW = $clog2(RETENTION + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [ROW_AW-1:0] clr_row,
   output logic [ROWS-1:0]   expired
);

   if (RETENTION < 2) begin : g_bad_ret
      $error("dbank_retention: RETENTION must be at least 2");
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [RW-1:0] age_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            age_q <= '0;
         else if (clr && clr_row == ROW_AW'(r))
            age_q <= '0;
         else if (age_q != RW'(RETENTION))
            age_q <= age_q + 1'b1;
      end
      assign expired[r] = (age_q == RW'(RETENTION));
   end

   // R11
   clr_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !expired[$past(clr_row)]);
   // R10
   expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired[0] && !(clr && clr_row == '0)) |=> expired[0]);

endmodule

// File: rtl/dbank_array.sv
module dbank_array #(
   parameter int ROWS = 16,
   parameter int ROW_W = 32,
   localparam int ROW_AW = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sense_en,
   input  logic [ROW_AW-1:0] sense_row,
   output logic [ROW_W-1:0]  sense_data,
   input  logic              restore_en,
   input  logic [ROW_AW-1:0] restore_row,
   input  logic [ROW_W-1:0]  restore_data,
   input  logic              clear_en,
   input  logic [ROW_AW-1:0] clear_row
);

   logic [ROW_W-1:0] row_bus [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_cell
      logic             hit_restore, hit_drain;
      logic [ROW_W-1:0] cell_q;
      assign hit_restore = restore_en && restore_row == ROW_AW'(r);
      assign hit_drain   = (sense_en && sense_row == ROW_AW'(r))
                        || (clear_en && clear_row == ROW_AW'(r));
      always_ff @(posedge clk) begin
         if (!rst_n)           cell_q <= '0;
         else if (hit_restore) cell_q <= restore_data;
         else if (hit_drain)   cell_q <= '0;
      end
      assign row_bus[r] = cell_q;
   end

   assign sense_data = row_bus[sense_row];

   // R5
   sense_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_en && !restore_en) |=> row_bus[$past(sense_row)] == '0);
   // R5
   restore_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_en |=> row_bus[$past(restore_row)] == $past(restore_data));

endmodule

// File: rtl/dbank_model.sv
module dbank_model
   import dbank_pkg::*;
#(
   parameter int ROWS = 16,
   parameter int ROW_W = 32,
   parameter int COL_W = 8,
   parameter int T_ACT = 4,
   parameter int T_PRE = 8,
   parameter int T_COL = 1,
   parameter int RETENTION = 4096,
   localparam int COLS = ROW_W / COL_W,
   localparam int ROW_AW = $clog2(ROWS),
   localparam int COL_AW = $clog2(COLS),
   localparam int ADDR_W = ROW_AW + COL_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [COL_W-1:0]  cmd_wdata,
   output logic              busy,
   output logic              rd_valid,
   output logic [COL_W-1:0]  rd_data,
   output logic              cmd_error,
   output logic              decay_error
);

   if (ROW_W % COL_W != 0 || COLS < 2 || (1 << COL_AW) != COLS) begin : g_bad_cols
      $error("dbank_model: ROW_W must be a power-of-two multiple (>=2) of COL_W");
   end
   if (ROWS < 2 || (1 << ROW_AW) != ROWS) begin : g_bad_rows
      $error("dbank_model: ROWS must be a power of two, at least 2");
   end

   dbank_op_e         op;
   logic [ROW_AW-1:0] row;
   logic [COL_AW-1:0] col;
   logic              known_op, col_op, opens_op, illegal, take, done;
   logic [ROWS-1:0]   expired;
   logic [ROW_W-1:0]  sense_data;

   logic              open_q, dec_q, rd_pend_q, dec_hold_q;
   logic [ROW_AW-1:0] open_row_q;
   logic [ROW_W-1:0]  rowbuf_q;
   logic [COL_W-1:0]  rd_hold_q;

   assign op       = dbank_op_e'(cmd_op);
   assign row      = cmd_addr[ADDR_W-1:COL_AW];
   assign col      = cmd_addr[COL_AW-1:0];
   assign known_op = (op == OP_ACT) || (op == OP_RD) || (op == OP_WR)
                  || (op == OP_PRE) || (op == OP_REF);
   assign col_op   = (op == OP_RD) || (op == OP_WR);
   assign opens_op = (op == OP_ACT) || (op == OP_REF);
   assign illegal  = cmd_valid && known_op
                  && (busy || (col_op && !open_q) || (opens_op && open_q));
   assign take     = cmd_valid && known_op && !illegal;

   dbank_timer #(.T_ACT(T_ACT), .T_PRE(T_PRE), .T_COL(T_COL)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take),
      .op    (op),
      .busy  (busy),
      .done  (done)
   );

   dbank_retention #(.ROWS(ROWS), .RETENTION(RETENTION)) u_retention (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (take && ((op == OP_PRE && open_q) || op == OP_REF)),
      .clr_row ((op == OP_PRE) ? open_row_q : row),
      .expired (expired)
   );

   dbank_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
      .clk          (clk),
      .rst_n        (rst_n),
      .sense_en     (take && op == OP_ACT),
      .sense_row    (row),
      .sense_data   (sense_data),
      .restore_en   (take && op == OP_PRE && open_q),
      .restore_row  (open_row_q),
      .restore_data (rowbuf_q),
      .clear_en     (take && op == OP_REF && expired[row]),
      .clear_row    (row)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         dec_q      <= 1'b0;
         open_row_q <= '0;
         rowbuf_q   <= '0;
         rd_pend_q  <= 1'b0;
         rd_hold_q  <= '0;
         dec_hold_q <= 1'b0;
      end else begin
         if (take) begin
            case (op)
               OP_ACT: begin
                  open_q     <= 1'b1;
                  open_row_q <= row;
                  dec_q      <= expired[row];
                  rowbuf_q   <= expired[row] ? '0 : sense_data;
               end
               OP_WR:  rowbuf_q[col*COL_W +: COL_W] <= cmd_wdata;
               OP_RD: begin
                  rd_pend_q  <= 1'b1;
                  dec_hold_q <= dec_q;
                  rd_hold_q  <= dec_q ? '0 : rowbuf_q[col*COL_W +: COL_W];
               end
               OP_PRE: begin
                  open_q <= 1'b0;
                  dec_q  <= 1'b0;
               end
               default: ;
            endcase
         end else if (done) begin
            rd_pend_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_data     <= '0;
         decay_error <= 1'b0;
         cmd_error   <= 1'b0;
      end else begin
         rd_valid    <= done && rd_pend_q;
         decay_error <= done && rd_pend_q && dec_hold_q;
         cmd_error   <= illegal;
         if (done && rd_pend_q) rd_data <= rd_hold_q;
      end
   end

   // R4
   rd_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy);
   // R10
   decay_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decay_error |-> (rd_valid && rd_data == '0));
   // R9
   busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy && known_op) |=> cmd_error);
   // R7
   closed_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && col_op && !open_q) |=> (cmd_error && !busy));
   // R8
   reopen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && opens_op && open_q) |=> (open_q && open_row_q == $past(open_row_q)));

endmodule

// File: tb/test_dbank_model.sv
module test_dbank_model;
   localparam int ROWS = 16, ROW_W = 32, COL_W = 8;
   localparam int T_ACT = 4, T_PRE = 8, T_COL = 1, RET = 600;
   localparam int ROW_AW = 4, COL_AW = 2, COLS = 4;
   localparam int C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5;

   logic              clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
   logic [2:0]        cmd_op = '0;
   logic [ROW_AW+COL_AW-1:0] cmd_addr = '0;
   logic [COL_W-1:0]  cmd_wdata = '0;
   logic              busy, rd_valid, cmd_error, decay_error;
   logic [COL_W-1:0]  rd_data;

   dbank_model #(.RETENTION(RET)) i_dbank_model (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd_error(cmd_error),
      .decay_error(decay_error));

   always #5 clk = ~clk;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [ROW_W-1:0] m_mem [ROWS];
   int               m_clr [ROWS];
   bit               m_open, m_dec;
   int               m_orow;
   logic [ROW_W-1:0] m_buf;
   int checks = 0, fails = 0;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lat(int op);
      case (op)
         C_ACT: return T_ACT;
         C_PRE: return T_PRE;
         C_REF: return T_ACT + T_PRE;
         default: return T_COL;
      endcase
   endfunction

   function automatic bit aged(int row, int acc);
      return (acc - 1 - m_clr[row]) >= RET;
   endfunction

   task automatic do_op(int op, int row, int col, int data, string tag);
      int acc, nb, exp_d;
      bit ce, rv, de, known, bad;
      logic [COL_W-1:0] rd;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op);
      cmd_addr = {ROW_AW'(row), COL_AW'(col)}; cmd_wdata = COL_W'(data);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0;
      acc = cyc; ce = cmd_error; nb = 0;
      while (busy) begin nb++; @(negedge clk); end
      rv = rd_valid; rd = rd_data; de = decay_error;
      known = (op >= C_ACT && op <= C_REF);
      bad = known && (((op == C_RD || op == C_WR) && !m_open)
                  || ((op == C_ACT || op == C_REF) && m_open));
      exp_d = m_dec ? 0 : int'(m_buf[col*COL_W +: COL_W]);
      check({tag, " error"}, int'(ce), int'(bad));
      check({tag, " busy"}, nb, (known && !bad) ? lat(op) : 0);
      check({tag, " rd_valid"}, int'(rv), int'(op == C_RD && !bad));
      if (op == C_RD && !bad) begin
         check({tag, " data"}, int'(rd), exp_d);
         check({tag, " decay"}, int'(de), int'(m_dec));
      end
      if (known && !bad) begin
         case (op)
            C_ACT: begin
               m_open = 1; m_orow = row; m_dec = aged(row, acc);
               m_buf = m_dec ? '0 : m_mem[row];
            end
            C_WR: m_buf[col*COL_W +: COL_W] = COL_W'(data);
            C_PRE: if (m_open) begin
               m_mem[m_orow] = m_buf; m_clr[m_orow] = acc; m_open = 0; m_dec = 0;
            end
            C_REF: begin
               if (aged(row, acc)) m_mem[row] = '0;
               m_clr[row] = acc;
            end
            default: ;
         endcase
      end
   endtask

   task automatic refresh_all(string tag);
      if (m_open) do_op(C_PRE, 0, 0, 0, tag);
      for (int r = 0; r < ROWS; r++) do_op(C_REF, r, 0, 0, tag);
   endtask

   initial begin
      int busy_seen, rv_seen;
      void'($urandom(32'h1d5e_a7c3));
      for (int r = 0; r < ROWS; r++) begin m_mem[r] = '0; m_clr[r] = 0; end
      m_open = 0; m_dec = 0; m_buf = '0; m_orow = 0;
      repeat (4) @(negedge clk);
      check("R1 busy at reset", int'(busy), 0);
      check("R1 rd_valid at reset", int'(rd_valid), 0);
      check("R1 errors at reset", int'(cmd_error | decay_error), 0);
      rst_n = 1'b1;
      for (int r = 0; r < ROWS; r++) m_clr[r] = cyc;
      @(negedge clk);
      check("R1 busy after reset", int'(busy), 0);
      // R7: no row is open after reset
      do_op(C_RD, 0, 0, 0, "R7 read closed");
      // R2: unused codes are no-ops
      do_op(0, 1, 1, 0, "R2 code0");
      do_op(6, 1, 1, 0, "R2 code6");
      do_op(7, 1, 1, 0, "R2 code7");
      // R11: refresh of fresh rows
      refresh_all("R11 refresh");
      // R3 R5 R2: open, write every column, read back
      do_op(C_ACT, 2, 0, 0, "R3 act");
      for (int c = 0; c < COLS; c++) do_op(C_WR, 2, c, 8'h10 + c * 8'h11, "R5 write");
      for (int c = COLS - 1; c >= 0; c--) do_op(C_RD, 2, c, 0, "R2 R4 read column");
      do_op(C_PRE, 2, 0, 0, "R3 pre");
      do_op(C_ACT, 9, 0, 0, "R6 act");
      do_op(C_WR, 9, 0, 8'hc3, "R6 write");
      do_op(C_PRE, 9, 0, 0, "R6 pre");
      do_op(C_ACT, 2, 0, 0, "R5 reopen");
      for (int c = 0; c < COLS; c++) do_op(C_RD, 2, c, 0, "R5 R6 persisted");
      // R8: activate and refresh while open are dropped
      do_op(C_ACT, 9, 0, 0, "R8 act open");
      do_op(C_REF, 9, 0, 0, "R8 ref open");
      do_op(C_RD, 2, 1, 0, "R8 still row2");
      do_op(C_PRE, 0, 0, 0, "R3 pre");
      // R7: write with no row open is dropped
      do_op(C_WR, 2, 0, 8'h55, "R7 write closed");
      // R12
      do_op(C_PRE, 0, 0, 0, "R12 pre closed");
      do_op(C_ACT, 2, 0, 0, "R7 act");
      do_op(C_RD, 2, 0, 0, "R7 write ignored");
      do_op(C_PRE, 0, 0, 0, "R3 pre");
      // R9: command during busy
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'(C_ACT); cmd_addr = {4'd4, 2'd0};
      @(negedge clk);
      m_open = 1; m_orow = 4; m_dec = aged(4, cyc); m_buf = m_dec ? '0 : m_mem[4];
      cmd_op = 3'(C_RD);
      @(negedge clk);
      cmd_valid = 0; cmd_op = '0;
      check("R9 error while busy", int'(cmd_error), 1);
      busy_seen = 1; rv_seen = 0;
      while (busy) begin busy_seen++; rv_seen |= int'(rd_valid); @(negedge clk); end
      rv_seen |= int'(rd_valid);
      check("R9 read dropped", rv_seen, 0);
      check("R9 busy length", busy_seen, T_ACT);
      do_op(C_PRE, 0, 0, 0, "R9 pre");
      // R10 R11: decay and refresh
      do_op(C_ACT, 5, 0, 0, "R10 act5");
      do_op(C_WR, 5, 0, 8'ha5, "R10 wr5");
      do_op(C_PRE, 0, 0, 0, "R10 pre5");
      do_op(C_ACT, 6, 0, 0, "R10 act6");
      do_op(C_WR, 6, 0, 8'hb6, "R10 wr6");
      do_op(C_PRE, 0, 0, 0, "R10 pre6");
      repeat (RET * 2 / 3) @(negedge clk);
      do_op(C_REF, 5, 0, 0, "R11 ref5");
      repeat (RET * 2 / 3) @(negedge clk);
      do_op(C_ACT, 6, 0, 0, "R10 act decayed");
      check("R10 model sees decay", int'(m_dec), 1);
      do_op(C_RD, 6, 0, 0, "R10 read decayed");
      do_op(C_PRE, 0, 0, 0, "R10 pre decayed");
      do_op(C_ACT, 5, 0, 0, "R11 act refreshed");
      do_op(C_RD, 5, 0, 0, "R11 read refreshed");
      do_op(C_PRE, 0, 0, 0, "R11 pre");
      do_op(C_ACT, 6, 0, 0, "R10 act restored");
      do_op(C_RD, 6, 0, 0, "R10 read restored zero");
      do_op(C_PRE, 0, 0, 0, "R10 pre");
      do_op(C_REF, 2, 0, 0, "R11 ref decayed");
      do_op(C_ACT, 2, 0, 0, "R11 act");
      do_op(C_RD, 2, 3, 0, "R11 decayed ref zeroed");
      do_op(C_PRE, 0, 0, 0, "R11 pre");
      // random traffic, R2 R3 R4 R5 R6 R7 R8
      refresh_all("R11 refresh");
      for (int b = 0; b < 10; b++) begin
         for (int n = 0; n < 20; n++) begin
            int op;
            op = 1 + int'($urandom % 5);
            do_op(op, int'($urandom % ROWS), int'($urandom % COLS),
                  int'($urandom % 256), "R6 random");
         end
         refresh_all("R11 refresh");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule